// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block is the per-processor core that tracks interrupt requests and interrupts in service across 256 vectors. It holds three 256-bit state vectors: pending requests, vectors in service, and the trigger mode of each vector. A vector's priority class is its upper nibble, and among set bits the highest-numbered one wins.

Request sources post a vector together with a level/edge flag. The processor side writes a task priority and a control word that holds a software enable and a spurious vector. It acknowledges to claim the best pending vector and signals end-of-interrupt to retire the best vector in service. The block drives one interrupt line and reports the current processor priority. It also keeps a count of requests that landed on a bit that was previously clear.

The interrupt line and the processor priority are recomputed every cycle from the stored state. An acknowledge is answered one cycle later on a registered result port.

Top module: `vip_ctrl`

## Requirements
- R1: After synchronous reset: irq is 0, ppr is 0x00, deliv_cnt is 0, and the software enable is clear, so an acknowledge returns "none".
- R2: A request sets the vector's pending bit. It sets the vector's trigger-mode bit when req_level is 1 and clears it when req_level is 0. When the vector is later acknowledged, its trigger-mode bit appears on ack_level.
- R3: Among pending vectors, an acknowledge always selects the highest-numbered one.
- R4: Processor priority equals the task priority when the task class (bits 7:4) is at least the class of the highest vector in service. Otherwise it equals that class shifted left by 4. An empty in-service set counts as class 0.
- R5: irq is 1 only when the enable (control bit 8) is set and a request is pending, and in addition either ppr is 0 or the highest pending class is strictly greater than ppr bits 7:4. irq follows the state in the cycle after any change.
- R6: When the task priority is nonzero and the highest pending vector is less than or equal to it, an acknowledge returns control bits 7:0 with ack_none=0 and leaves all pending and in-service state unchanged.
- R7: Otherwise an enabled acknowledge clears the highest pending bit, sets the same in-service bit, and returns that vector. ack_valid, ack_vec, ack_none and ack_level are valid in the cycle after ack_req.
- R8: An acknowledge while the enable is clear or with nothing pending returns ack_none=1, ack_vec=0 and ack_level=0.
- R9: End-of-interrupt clears the highest set in-service bit. With nothing in service it has no effect.
- R10: A control write keeps svr_wdata bits 8:0 and ignores the upper bits. The reset value is 0x0FF, so the enable is clear.
- R11: deliv_cnt increments by one only when a request hits a pending bit that was clear. A repeated request for a vector that is already pending does not count.
- R12: When operations share a cycle, acknowledge and end-of-interrupt act on the state held before the edge. End-of-interrupt is applied before the acknowledged vector enters service, and a request is applied last. A request for the vector being acknowledged in the same cycle therefore stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Post a request this cycle |
| req_vec | input | 8 | Vector being requested |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | New task priority |
| svr_we | input | 1 | Control word write strobe |
| svr_wdata | input | 32 | Control word; bit 8 enable, bits 7:0 spurious vector |
| irq | output | 1 | Interrupt line to the processor |
| ppr | output | 8 | Current processor priority |
| ack_valid | output | 1 | Acknowledge result valid (one cycle after ack_req) |
| ack_none | output | 1 | No interrupt available for this acknowledge |
| ack_vec | output | 8 | Acknowledged or spurious vector |
| ack_level | output | 1 | Trigger mode of the acknowledged vector |
| deliv_cnt | output | 16 | Count of newly delivered requests (wraps) |

## Verification
Corrupt pending or in-service bits show up at the ports within one cycle: either irq holds the wrong level or ppr carries the wrong class. Vectors that do not move the class are hidden until an acknowledge or end-of-interrupt brings them to the top. The bench therefore drains every vector it posts through acknowledge and end-of-interrupt, and checks the returned vector and ppr at every step. A stale trigger-mode bit is visible only on ack_level when its vector is claimed. The bench re-posts vectors with the opposite flag before claiming them so that such a bit cannot go unnoticed.

// File: rtl/vip_pkg.sv
// Package: shared types for the vectored interrupt priority controller.
// Assumes: nothing beyond standard SystemVerilog.
package vip_pkg;

    // Outcome of an acknowledge, decided from the state before the edge.
    typedef enum logic [1:0] {
        ACK_NONE = 2'd0,   // disabled or nothing pending
        ACK_SPUR = 2'd1,   // blocked by task priority
        ACK_TAKE = 2'd2    // vector moves into service
    } ack_kind_e;

endpackage

// File: rtl/vip_prio_enc.sv
// Module: highest-set-bit encoder for a wide request vector.
// The input is split into groups. Each group resolves its own top bit
// in parallel, and then the highest non-empty group is selected.
// Assumes: N and GROUP are powers of two and GROUP >= 2.
module vip_prio_enc #(
    parameter int N     = 256,
    parameter int GROUP = 16
) (
    input  logic [N-1:0]         bits_i,
    output logic                 any_o,
    output logic [$clog2(N)-1:0] idx_o
);
    localparam int IDX_W = $clog2(N);
    localparam int GW    = $clog2(GROUP);
    localparam int NG    = N / GROUP;

    logic [NG-1:0]    grp_any;
    logic [NG*GW-1:0] grp_idx;

    generate
        for (genvar g = 0; g < NG; g++) begin : g_grp
            logic [GROUP-1:0] slice;
            logic [GW-1:0]    loc;
            assign slice = bits_i[g*GROUP +: GROUP];
            // Find the highest set bit inside this group.
            always_comb begin
                loc = '0;
                for (int i = 0; i < GROUP; i++) begin
                    if (slice[i]) loc = GW'(i);
                end
            end
            assign grp_any[g]            = |slice;
            assign grp_idx[g*GW +: GW]   = loc;
        end
    endgenerate

    // Pick the highest non-empty group and form the full index.
    always_comb begin
        any_o = |grp_any;
        idx_o = '0;
        for (int g = 0; g < NG; g++) begin
            if (grp_any[g]) idx_o = IDX_W'(g * GROUP) + IDX_W'(grp_idx[g*GW +: GW]);
        end
    end
endmodule

// File: rtl/vip_prio_eval.sv
// Module: processor priority, interrupt line and acknowledge blocking.
// Purely combinational. It is fed by the top vectors of the pending and
// in-service sets.
// Assumes: the class is the upper VEC_W-SUB_W bits of a vector.
module vip_prio_eval #(
    parameter int VEC_W = 8,
    parameter int SUB_W = 4
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             sw_en_i,
    input  logic             pend_any_i,
    input  logic [VEC_W-1:0] pend_top_i,
    input  logic             svc_any_i,
    input  logic [VEC_W-1:0] svc_top_i,
    output logic [VEC_W-1:0] ppr_o,
    output logic             irq_o,
    output logic             blocked_o
);
    localparam int CLS_W = VEC_W - SUB_W;

    logic [CLS_W-1:0] tpr_cls;
    logic [CLS_W-1:0] svc_cls;
    logic [CLS_W-1:0] pend_cls;

    // Extract the classes; an empty in-service set counts as class 0.
    always_comb begin
        tpr_cls  = tpr_i[VEC_W-1 -: CLS_W];
        pend_cls = pend_top_i[VEC_W-1 -: CLS_W];
        svc_cls  = svc_any_i ? svc_top_i[VEC_W-1 -: CLS_W] : '0;
    end

    // Processor priority: the task priority unless in-service work outranks it.
    always_comb begin
        if (tpr_cls >= svc_cls) ppr_o = tpr_i;
        else                    ppr_o = {svc_cls, {SUB_W{1'b0}}};
    end

    // Interrupt line and acknowledge blocking decisions.
    always_comb begin
        irq_o     = sw_en_i && pend_any_i &&
                    ((ppr_o == '0) || (pend_cls > ppr_o[VEC_W-1 -: CLS_W]));
        blocked_o = (tpr_i != '0) && (pend_top_i <= tpr_i);
    end
endmodule

// File: rtl/vip_ctrl.sv
// Module: vectored interrupt priority controller (top).
// Holds the pending, in-service and trigger-mode sets, the task priority,
// the control word and the delivery count. Same-cycle ordering: acknowledge
// and EOI use the old state, EOI is applied before the acknowledged vector
// enters service, and a request is applied last.
// Assumes: synchronous active-low reset; NUM_VEC is a power of two >= 32.
module vip_ctrl
    import vip_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int GROUP   = 16,
    parameter int SUB_W   = 4,
    parameter int CNT_W   = 16,
    parameter int BUS_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [$clog2(NUM_VEC)-1:0] req_vec,
    input  logic                       req_level,
    input  logic                       ack_req,
    input  logic                       eoi,
    input  logic                       tpr_we,
    input  logic [$clog2(NUM_VEC)-1:0] tpr_wdata,
    input  logic                       svr_we,
    input  logic [BUS_W-1:0]           svr_wdata,
    output logic                       irq,
    output logic [$clog2(NUM_VEC)-1:0] ppr,
    output logic                       ack_valid,
    output logic                       ack_none,
    output logic [$clog2(NUM_VEC)-1:0] ack_vec,
    output logic                       ack_level,
    output logic [CNT_W-1:0]           deliv_cnt
);
    localparam int VEC_W = $clog2(NUM_VEC);
    localparam int SVR_W = VEC_W + 1;

    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
    logic [VEC_W-1:0]   tpr_q;
    logic [SVR_W-1:0]   svr_q;

    logic             pend_any, svc_any, blocked, sw_en;
    logic [VEC_W-1:0] pend_top, svc_top;
    ack_kind_e        ack_kind;

    assign sw_en = svr_q[VEC_W];

    vip_prio_enc #(.N(NUM_VEC), .GROUP(GROUP)) u_pend_enc (
        .bits_i (irr_q),
        .any_o  (pend_any),
        .idx_o  (pend_top)
    );

    vip_prio_enc #(.N(NUM_VEC), .GROUP(GROUP)) u_svc_enc (
        .bits_i (isr_q),
        .any_o  (svc_any),
        .idx_o  (svc_top)
    );

    vip_prio_eval #(.VEC_W(VEC_W), .SUB_W(SUB_W)) u_eval (
        .tpr_i      (tpr_q),
        .sw_en_i    (sw_en),
        .pend_any_i (pend_any),
        .pend_top_i (pend_top),
        .svc_any_i  (svc_any),
        .svc_top_i  (svc_top),
        .ppr_o      (ppr),
        .irq_o      (irq),
        .blocked_o  (blocked)
    );

    // Classify the acknowledge from the state before the edge.
    always_comb begin
        if (!sw_en || !pend_any) ack_kind = ACK_NONE;
        else if (blocked)        ack_kind = ACK_SPUR;
        else                     ack_kind = ACK_TAKE;
    end

    // Next state of the vector sets: EOI, then acknowledge, then request.
    always_comb begin
        irr_n = irr_q;
        isr_n = isr_q;
        tmr_n = tmr_q;
        if (eoi && svc_any) isr_n[svc_top] = 1'b0;
        if (ack_req && ack_kind == ACK_TAKE) begin
            irr_n[pend_top] = 1'b0;
            isr_n[pend_top] = 1'b1;
        end
        if (req_valid) begin
            irr_n[req_vec] = 1'b1;
            tmr_n[req_vec] = req_level;
        end
    end

    // State registers for vector sets, task priority and control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
            tpr_q <= '0;
            svr_q <= {1'b0, {VEC_W{1'b1}}};
        end else begin
            irr_q <= irr_n;
            isr_q <= isr_n;
            tmr_q <= tmr_n;
            if (tpr_we) tpr_q <= tpr_wdata;
            if (svr_we) svr_q <= svr_wdata[SVR_W-1:0];
        end
    end

    // Registered acknowledge result, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_none  <= 1'b0;
            ack_vec   <= '0;
            ack_level <= 1'b0;
        end else begin
            ack_valid <= ack_req;
            ack_none  <= ack_req && (ack_kind == ACK_NONE);
            ack_level <= ack_req && (ack_kind == ACK_TAKE) && tmr_q[pend_top];
            if (!ack_req)                  ack_vec <= '0;
            else if (ack_kind == ACK_TAKE) ack_vec <= pend_top;
            else if (ack_kind == ACK_SPUR) ack_vec <= svr_q[VEC_W-1:0];
            else                           ack_vec <= '0;
        end
    end

    // Count requests that land on a previously clear pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                           deliv_cnt <= '0;
        else if (req_valid && !irr_q[req_vec]) deliv_cnt <= deliv_cnt + 1'b1;
    end

    // R5: the line is never raised while disabled or with nothing pending.
    a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (svr_q[VEC_W] && (irr_q != '0)));

    // R4: processor priority never falls below the task priority.
    a_r4_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= tpr_q);

    // R7: a taken vector is in service after the edge.
    a_r7_take_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_kind == ACK_TAKE) |=> isr_q[$past(pend_top)]);

    // R6: a blocked acknowledge leaves both sets unchanged.
    a_r6_spur_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_kind == ACK_SPUR && !req_valid && !eoi)
        |=> (irr_q == $past(irr_q)) && (isr_q == $past(isr_q)));

    // R9: EOI with nothing in service changes nothing.
    a_r9_eoi_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (isr_q == '0) && !ack_req) |=> (isr_q == $past(isr_q)));

    // R11: a repeated request does not advance the count.
    a_r11_dup_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && irr_q[req_vec]) |=> (deliv_cnt == $past(deliv_cnt)));

    // R8: a "none" result carries a zero vector and edge mode.
    a_r8_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_none) |-> (ack_vec == '0 && !ack_level));
endmodule

// File: tb/vip_ctrl_tb_top.sv
`timescale 1ns/1ps
module vip_ctrl_tb_top;
    localparam logic [2:0] OP_ACK = 3'd0;
    localparam logic [2:0] OP_REQ = 3'd1;
    localparam logic [2:0] OP_EOI = 3'd2;
    localparam logic [2:0] OP_TPR = 3'd3;
    localparam logic [2:0] OP_SVR = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] data;
        logic        lvl;
        logic        e_irq;
        logic [7:0]  e_ppr;
        logic        e_none;
        logic [7:0]  e_vec;
        logic        e_lvl;
    } row_t;

    localparam int NROWS = 13;
    localparam row_t TBL [NROWS] = '{
        '{OP_ACK, 32'h0,         1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0},
        '{OP_SVR, 32'hABCD_E10F, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
        '{OP_REQ, 32'h45,        1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0},
        '{OP_REQ, 32'h82,        1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0},
        '{OP_TPR, 32'h90,        1'b0, 1'b0, 8'h90, 1'b0, 8'h00, 1'b0},
        '{OP_ACK, 32'h0,         1'b0, 1'b0, 8'h90, 1'b0, 8'h0F, 1'b0},
        '{OP_TPR, 32'h30,        1'b0, 1'b1, 8'h30, 1'b0, 8'h00, 1'b0},
        '{OP_ACK, 32'h0,         1'b0, 1'b0, 8'h80, 1'b0, 8'h82, 1'b1},
        '{OP_ACK, 32'h0,         1'b0, 1'b0, 8'h80, 1'b0, 8'h45, 1'b0},
        '{OP_EOI, 32'h0,         1'b0, 1'b0, 8'h40, 1'b0, 8'h00, 1'b0},
        '{OP_EOI, 32'h0,         1'b0, 1'b0, 8'h30, 1'b0, 8'h00, 1'b0},
        '{OP_EOI, 32'h0,         1'b0, 1'b0, 8'h30, 1'b0, 8'h00, 1'b0},
        '{OP_ACK, 32'h0,         1'b0, 1'b0, 8'h30, 1'b1, 8'h00, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_level = 1'b0, ack_req = 1'b0, eoi = 1'b0;
    logic [7:0]  req_vec = '0, tpr_wdata = '0;
    logic        tpr_we = 1'b0, svr_we = 1'b0;
    logic [31:0] svr_wdata = '0;
    logic        irq, ack_valid, ack_none, ack_level;
    logic [7:0]  ppr, ack_vec;
    logic [15:0] deliv_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vip_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
        .ack_req(ack_req), .eoi(eoi),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .svr_we(svr_we), .svr_wdata(svr_wdata),
        .irq(irq), .ppr(ppr),
        .ack_valid(ack_valid), .ack_none(ack_none), .ack_vec(ack_vec),
        .ack_level(ack_level), .deliv_cnt(deliv_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Let the driven strobes take one edge, clear them, sample at the next negedge.
    task automatic tick();
        @(posedge clk);
        #1;
        req_valid = 1'b0; ack_req = 1'b0; eoi = 1'b0;
        tpr_we = 1'b0; svr_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_op(input logic [2:0] op, input logic [31:0] data, input logic lvl);
        case (op)
            OP_ACK: ack_req = 1'b1;
            OP_REQ: begin req_valid = 1'b1; req_vec = data[7:0]; req_level = lvl; end
            OP_EOI: eoi = 1'b1;
            OP_TPR: begin tpr_we = 1'b1; tpr_wdata = data[7:0]; end
            default: begin svr_we = 1'b1; svr_wdata = data; end
        endcase
        tick();
    endtask

    task automatic chk_ack(input string tag, input logic none, input logic [7:0] v, input logic l);
        chk({tag, " ack_valid"}, ack_valid, 1'b1);
        chk({tag, " ack_none"}, ack_none, none);
        chk({tag, " ack_vec"}, ack_vec, v);
        chk({tag, " ack_level"}, ack_level, l);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1 irq", irq, 0);
        chk("R1 ppr", ppr, 0);
        chk("R1 count", deliv_cnt, 0);

        // Table: R3, R4, R5, R6, R7, R8, R9, R10.
        for (int r = 0; r < NROWS; r++) begin
            do_op(TBL[r].op, TBL[r].data, TBL[r].lvl);
            chk($sformatf("row %0d R5 irq", r), irq, TBL[r].e_irq);
            chk($sformatf("row %0d R4 ppr", r), ppr, TBL[r].e_ppr);
            if (TBL[r].op == OP_ACK)
                chk_ack($sformatf("row %0d R3 R7", r), TBL[r].e_none, TBL[r].e_vec, TBL[r].e_lvl);
        end
        chk("R11 count after table", deliv_cnt, 2);

        // R11: a repeated request does not count.
        do_op(OP_TPR, 32'h0, 1'b0);
        do_op(OP_REQ, 32'h20, 1'b0);
        do_op(OP_REQ, 32'h20, 1'b0);
        chk("R11 dup count", deliv_cnt, 3);
        chk("R5 irq tpr zero", irq, 1);

        // R12: acknowledge and request of the same vector in one cycle.
        req_valid = 1'b1; req_vec = 8'h20; req_level = 1'b0; ack_req = 1'b1;
        tick();
        chk_ack("R12 same-cycle", 1'b0, 8'h20, 1'b0);
        chk("R12 ppr", ppr, 8'h20);
        chk("R12 irq", irq, 0);
        chk("R12 count", deliv_cnt, 3);
        do_op(OP_ACK, 0, 0);
        chk_ack("R12 still pending", 1'b0, 8'h20, 1'b0);
        do_op(OP_EOI, 0, 0);
        chk("R9 ppr after eoi", ppr, 0);

        // R2: trigger mode follows the latest request.
        do_op(OP_REQ, 32'h50, 1'b1);
        do_op(OP_REQ, 32'h50, 1'b0);
        do_op(OP_ACK, 0, 0);
        chk_ack("R2 level then edge", 1'b0, 8'h50, 1'b0);
        do_op(OP_EOI, 0, 0);
        do_op(OP_REQ, 32'h60, 1'b1);
        do_op(OP_ACK, 0, 0);
        chk_ack("R2 level", 1'b0, 8'h60, 1'b1);
        do_op(OP_EOI, 0, 0);
        chk("R11 count", deliv_cnt, 5);

        // R10 / R6: upper bits dropped; boundary pend == tpr is blocked.
        do_op(OP_SVR, 32'h0000_0377, 0);
        do_op(OP_TPR, 32'hF0, 0);
        do_op(OP_REQ, 32'hF0, 0);
        chk("R5 irq blocked class", irq, 0);
        do_op(OP_ACK, 0, 0);
        chk_ack("R6 R10 spurious", 1'b0, 8'h77, 1'b0);
        do_op(OP_TPR, 32'hEF, 0);
        chk("R5 irq above tpr", irq, 1);
        do_op(OP_ACK, 0, 0);
        chk_ack("R6 just above tpr", 1'b0, 8'hF0, 1'b0);
        chk("R4 ppr svc class", ppr, 8'hF0);
        do_op(OP_EOI, 0, 0);
        chk("R4 ppr back to tpr", ppr, 8'hEF);

        // R5 / R8: disabled means no line and "none" even when pending.
        do_op(OP_TPR, 32'h0, 0);
        do_op(OP_SVR, 32'h0AA, 0);
        do_op(OP_REQ, 32'h33, 0);
        chk("R5 irq disabled", irq, 0);
        do_op(OP_ACK, 0, 0);
        chk_ack("R8 disabled", 1'b1, 8'h00, 1'b0);
        do_op(OP_SVR, 32'h1AA, 0);
        chk("R5 irq enabled", irq, 1);
        do_op(OP_ACK, 0, 0);
        chk_ack("R7 after enable", 1'b0, 8'h33, 1'b0);

        // R1: reset in mid-run.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq after reset", irq, 0);
        chk("R1 ppr after reset", ppr, 0);
        chk("R1 count after reset", deliv_cnt, 0);
        do_op(OP_REQ, 32'h10, 0);
        do_op(OP_ACK, 0, 0);
        chk_ack("R1 R10 enable clear", 1'b1, 8'h00, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule